// File: doc/BRIEF.md
# Repeater AUX Request Router

This block sits in a link repeater on the upstream side of the sideband AUX channel. Each cycle that a decoded request is presented (command, 20-bit register address, byte count, first data byte) it produces a one-cycle routing decision. There are four possible decisions. The request is forwarded downstream. Or the repeater answers it locally. Or the repeater returns a fixed negative acknowledge with a written count of zero. Or the repeater returns a fixed acknowledge with zero-filled data. The repeater's chain position (1 nearest the sink, up to 8) is a static input.

The block holds one mode bit, written by the upstream source through the shared capability field. In transparent mode every request passes straight through. In non-transparent mode the repeater answers the shared capability field and its own configuration window. Windows of repeaters further downstream are passed on. Windows that no downstream repeater can own get the fixed replies.

Independently of routing, any access to the link-configuration range pulses a snoop strobe, so that the output stage can follow training writes.

Top module: `auxReqRouter`

## Requirements
- R1: After reset, nonTransparent is 0, decValid is 0 and snoopStrobe is 0.
- R2: decValid is high for exactly the cycle after each cycle in which reqValid is high, including back-to-back requests, and low otherwise.
- R3: While nonTransparent is 0, every request yields decAction 2'b00 (forward).
- R4: While nonTransparent is 1, a request starting in F0000h–F000Fh yields decAction 2'b01 (answer locally), for any position value.
- R5: While nonTransparent is 1 and rptPosition is n in 1..8, a request starting in F0010h+(n−1)×50h through F0010h+n×50h−1 yields decAction 2'b01.
- R6: While nonTransparent is 1, a request starting in the window of a position k with 1 ≤ k < n (a repeater downstream of this one) yields decAction 2'b00.
- R7: While nonTransparent is 1, a request starting in any other window inside F0010h–F028Fh yields decAction 2'b10 (NACK with M=0) for a write (reqIsWrite=1) and 2'b11 (ACK with zero data) for a read.
- R8: While nonTransparent is 1, a request starting outside F0000h–F028Fh yields decAction 2'b00.
- R9: snoopStrobe is high together with decValid exactly when the request started in 00100h–002FFh, for reads and writes and in both modes.
- R10: A write starting at F0003h with reqWrData 55h clears nonTransparent and with AAh sets it, from the following cycle on. Any other data value leaves the mode unchanged. The decision for that mode write itself uses the mode held before it.
- R11: Classification uses the starting address only; reqLen does not affect decAction.
- R12: decLen repeats the reqLen of the request being decided.
- R13: A rptPosition of 0 or above 8 owns no window and has no downstream windows, so every window access in non-transparent mode gets the fixed reply of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A decoded request is present this cycle |
| reqIsWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 20 | Starting register address |
| reqLen | input | 4 | Byte count field of the request |
| reqWrData | input | 8 | First write data byte |
| rptPosition | input | 4 | This repeater's chain position, 1..8 valid |
| decValid | output | 1 | Decision present this cycle |
| decAction | output | 2 | 00 forward, 01 local, 10 NACK M=0, 11 ACK zero data |
| decLen | output | 4 | Byte count of the decided request |
| snoopStrobe | output | 1 | Request touched the link-configuration range |
| nonTransparent | output | 1 | Current mode, 1 = non-transparent |

## Verification
Each decision and its snoop strobe are registered once, so they are due one cycle after the request was presented. The bench drives inputs on a falling edge and samples on the next falling edge, after exactly one rising edge has passed. The mode bit changes on the same rising edge that registers the mode write's own decision. That decision is therefore checked against the old mode, while the mode output and the next request are checked against the new one. One cycle after each request the bench also expects decValid low again, and a back-to-back pair is sampled on two consecutive falling edges.

// File: rtl/auxRouterPkg.sv
package auxRouterPkg;

  typedef enum logic [1:0] {
    ACT_FORWARD  = 2'b00,
    ACT_LOCAL    = 2'b01,
    ACT_NACK_M0  = 2'b10,
    ACT_ACK_ZERO = 2'b11
  } routeAct_e;

  // decode results handed from datapath to control
  typedef struct packed {
    logic isWrite;
    logic inCap;
    logic inOwn;
    logic inDownWin;
    logic inOtherWin;
    logic inSnoop;
    logic modeToT;
    logic modeToNT;
  } addrHits_t;

  // strobes handed from control to datapath
  typedef struct packed {
    logic      fire;
    routeAct_e act;
    logic      snoop;
  } ctlStrobe_t;

endpackage

// File: rtl/auxRouteDatapath.sv
module auxRouteDatapath
  import auxRouterPkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned LEN_W     = 4,
  parameter int unsigned POS_W     = 4,
  parameter int unsigned MAX_RPT   = 8,
  parameter int unsigned CAP_BASE  = 32'hF0000,
  parameter int unsigned CAP_SIZE  = 16,
  parameter int unsigned WIN_BASE  = 32'hF0010,
  parameter int unsigned WIN_SIZE  = 32'h50,
  parameter int unsigned SNP_LO    = 32'h00100,
  parameter int unsigned SNP_HI    = 32'h002FF,
  parameter int unsigned MODE_ADDR = 32'hF0003,
  parameter logic [7:0]  MODE_T    = 8'h55,
  parameter logic [7:0]  MODE_NT   = 8'hAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqIsWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [7:0]        reqWrData,
  input  logic [POS_W-1:0]  rptPosition,
  input  ctlStrobe_t        ctl,
  output addrHits_t         hits,
  output logic              decValid,
  output logic [1:0]        decAction,
  output logic [LEN_W-1:0]  decLen,
  output logic              snoopStrobe
);

  localparam int unsigned CAP_END = CAP_BASE + CAP_SIZE;

  logic [31:0]        addrExt;
  logic [31:0]        posExt;
  logic               posValid;
  logic [MAX_RPT-1:0] winHit;
  logic [MAX_RPT-1:0] ownMask;
  logic [MAX_RPT-1:0] downMask;

  assign addrExt  = 32'(reqAddr);
  assign posExt   = 32'(rptPosition);
  assign posValid = (posExt >= 32'd1) && (posExt <= MAX_RPT);

  for (genvar k = 0; k < MAX_RPT; k++) begin : gWin
    localparam int unsigned LO = WIN_BASE + k * WIN_SIZE;
    localparam int unsigned HI = LO + WIN_SIZE;
    assign winHit[k]   = (addrExt >= LO) && (addrExt < HI);
    assign ownMask[k]  = posValid && (posExt == (k + 1));
    assign downMask[k] = posValid && ((k + 1) < posExt);
  end

  always_comb begin
    hits            = '0;
    hits.isWrite    = reqIsWrite;
    hits.inCap      = (addrExt >= CAP_BASE) && (addrExt < CAP_END);
    hits.inOwn      = |(winHit & ownMask);
    hits.inDownWin  = |(winHit & downMask);
    hits.inOtherWin = (|winHit) && !hits.inOwn && !hits.inDownWin;
    hits.inSnoop    = (addrExt >= SNP_LO) && (addrExt <= SNP_HI);
    hits.modeToT    = reqIsWrite && (addrExt == MODE_ADDR) && (reqWrData == MODE_T);
    hits.modeToNT   = reqIsWrite && (addrExt == MODE_ADDR) && (reqWrData == MODE_NT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid    <= 1'b0;
      decAction   <= ACT_FORWARD;
      decLen      <= '0;
      snoopStrobe <= 1'b0;
    end else begin
      decValid    <= ctl.fire;
      snoopStrobe <= ctl.fire && ctl.snoop;
      if (ctl.fire) begin
        decAction <= ctl.act;
        decLen    <= reqLen;
      end
    end
  end

  AST_SNOOP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    snoopStrobe |-> decValid); // R9

  AST_LEN_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fire |=> (decLen == $past(reqLen))); // R12

endmodule

// File: rtl/auxRouteCtrl.sv
module auxRouteCtrl
  import auxRouterPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  addrHits_t  hits,
  output ctlStrobe_t ctl,
  output logic       modeNT
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeNT <= 1'b0;
    end else if (reqValid) begin
      if (hits.modeToNT)     modeNT <= 1'b1;
      else if (hits.modeToT) modeNT <= 1'b0;
    end
  end

  always_comb begin
    ctl       = '0;
    ctl.fire  = reqValid;
    ctl.snoop = hits.inSnoop;
    ctl.act   = ACT_FORWARD;
    if (modeNT) begin
      if (hits.inCap || hits.inOwn)
        ctl.act = ACT_LOCAL;
      else if (hits.inOtherWin)
        ctl.act = hits.isWrite ? ACT_NACK_M0 : ACT_ACK_ZERO;
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && (hits.modeToT || hits.modeToNT)) |=> $stable(modeNT)); // R10

  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hits.modeToT, hits.modeToNT})); // R10

endmodule

// File: rtl/auxReqRouter.sv
module auxReqRouter
  import auxRouterPkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned POS_W   = 4,
  parameter int unsigned MAX_RPT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [7:0]        reqWrData,
  input  logic [POS_W-1:0]  rptPosition,
  output logic              decValid,
  output logic [1:0]        decAction,
  output logic [LEN_W-1:0]  decLen,
  output logic              snoopStrobe,
  output logic              nonTransparent
);

  addrHits_t  hits;
  ctlStrobe_t ctl;

  auxRouteDatapath #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .POS_W  (POS_W),
    .MAX_RPT(MAX_RPT)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .reqIsWrite (reqIsWrite),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .reqWrData  (reqWrData),
    .rptPosition(rptPosition),
    .ctl        (ctl),
    .hits       (hits),
    .decValid   (decValid),
    .decAction  (decAction),
    .decLen     (decLen),
    .snoopStrobe(snoopStrobe)
  );

  auxRouteCtrl uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .hits    (hits),
    .ctl     (ctl),
    .modeNT  (nonTransparent)
  );

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> decValid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !decValid); // R2

  AST_TRANSPARENT_FWD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !nonTransparent) |=> (decAction == 2'b00)); // R3

  AST_SNOOP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqAddr >= ADDR_W'(32'h100)) && (reqAddr <= ADDR_W'(32'h2FF)))
      |=> snoopStrobe); // R9

  AST_FIXED_NEEDS_NT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (decAction != 2'b00 || 1'b1) && !nonTransparent) |=> (decAction != 2'b10 && decAction != 2'b11)); // R7

endmodule

// File: tb/auxReqRouter_test.sv
module auxReqRouter_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       reqValid;
  logic       reqIsWrite;
  logic [19:0] reqAddr;
  logic [3:0] reqLen;
  logic [7:0] reqWrData;
  logic [3:0] rptPosition;
  logic       decValid;
  logic [1:0] decAction;
  logic [3:0] decLen;
  logic       snoopStrobe;
  logic       nonTransparent;

  int nVec = 0;
  int nBad = 0;
  bit tbNT = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  auxReqRouter uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsWrite(reqIsWrite),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqWrData(reqWrData),
    .rptPosition(rptPosition), .decValid(decValid), .decAction(decAction),
    .decLen(decLen), .snoopStrobe(snoopStrobe), .nonTransparent(nonTransparent)
  );

  task automatic checkEq(string tag, string what, int act, int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int modelAct(bit nt, int pos, bit wr, int addr);
    int k;
    if (!nt) return 0;
    if (addr >= 'hF0000 && addr <= 'hF000F) return 1;
    if (addr >= 'hF0010 && addr <= 'hF028F) begin
      k = (addr - 'hF0010) / 'h50 + 1;
      if (pos >= 1 && pos <= 8 && k == pos) return 1;
      if (pos >= 1 && pos <= 8 && k < pos) return 0;
      return wr ? 2 : 3;
    end
    return 0;
  endfunction

  task automatic sendReq(string tag, bit wr, int addr, int len, int data, int pos);
    int exp;
    bit oldNT;
    @(negedge clk);
    reqValid    = 1'b1;
    reqIsWrite  = wr;
    reqAddr     = 20'(addr);
    reqLen      = 4'(len);
    reqWrData   = 8'(data);
    rptPosition = 4'(pos);
    oldNT = tbNT;
    exp = modelAct(oldNT, pos, wr, addr);
    if (wr && addr == 'hF0003 && data == 'h55) tbNT = 1'b0;
    if (wr && addr == 'hF0003 && data == 'hAA) tbNT = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    checkEq("R2", "decValid", int'(decValid), 1);
    checkEq(tag, "decAction", int'(decAction), exp);
    checkEq("R9", "snoopStrobe", int'(snoopStrobe),
            (addr >= 'h100 && addr <= 'h2FF) ? 1 : 0);
    checkEq("R12", "decLen", int'(decLen), len);
    checkEq("R10", "nonTransparent", int'(nonTransparent), int'(tbNT));
    @(negedge clk);
    checkEq("R2", "decValid idle", int'(decValid), 0);
  endtask

  task automatic testReset();
    checkEq("R1", "nonTransparent", int'(nonTransparent), 0);
    checkEq("R1", "decValid", int'(decValid), 0);
    checkEq("R1", "snoopStrobe", int'(snoopStrobe), 0);
  endtask

  task automatic testTransparent();
    sendReq("R3", 1'b0, 'h00000, 15, 0, 1);
    sendReq("R3", 1'b1, 'h00102, 1, 0, 1);
    sendReq("R3", 1'b0, 'hF0000, 4, 0, 1);
    sendReq("R3", 1'b1, 'hF0010, 0, 0, 1);
    sendReq("R3", 1'b0, 'hF0100, 3, 0, 1);
    sendReq("R3", 1'b0, 'hF0290, 0, 0, 1);
  endtask

  task automatic testModeWrites();
    sendReq("R10", 1'b1, 'hF0003, 0, 'h12, 1);
    sendReq("R10", 1'b1, 'hF0002, 1, 'hAA, 1);
    sendReq("R10", 1'b1, 'hF0003, 0, 'hAA, 1);
  endtask

  task automatic testCap();
    sendReq("R4", 1'b0, 'hF0000, 4, 0, 3);
    sendReq("R4", 1'b1, 'hF000F, 0, 0, 3);
    sendReq("R4", 1'b0, 'hF0004, 0, 0, 0);
  endtask

  task automatic testWindows();
    sendReq("R5", 1'b0, 'hF00B0, 0, 0, 3);
    sendReq("R5", 1'b1, 'hF00FF, 0, 0, 3);
    sendReq("R6", 1'b0, 'hF0060, 2, 0, 3);
    sendReq("R6", 1'b1, 'hF0010, 2, 0, 3);
    sendReq("R7", 1'b1, 'hF0100, 2, 0, 3);
    sendReq("R7", 1'b0, 'hF0100, 2, 0, 3);
    sendReq("R7", 1'b0, 'hF028F, 0, 0, 3);
    sendReq("R5", 1'b0, 'hF0240, 0, 0, 8);
    sendReq("R6", 1'b1, 'hF01F0, 0, 0, 8);
    sendReq("R5", 1'b1, 'hF0010, 0, 0, 1);
    sendReq("R7", 1'b0, 'hF0060, 0, 0, 1);
    for (int p = 1; p <= 8; p++)
      sendReq("R5", 1'b0, 'hF0010 + (p - 1) * 'h50 + 'h4F, 0, 0, p);
  endtask

  task automatic testOutside();
    sendReq("R8", 1'b0, 'hF0290, 0, 0, 2);
    sendReq("R8", 1'b1, 'h00000, 0, 0, 2);
    sendReq("R8", 1'b0, 'hFFFFF, 0, 0, 2);
    sendReq("R9", 1'b1, 'h002FF, 0, 0, 2);
    sendReq("R9", 1'b0, 'h00100, 0, 0, 2);
    sendReq("R9", 1'b0, 'h00300, 0, 0, 2);
    sendReq("R9", 1'b0, 'h000FF, 0, 0, 2);
  endtask

  task automatic testStartOnly();
    sendReq("R11", 1'b0, 'hF005F, 15, 0, 2);
    sendReq("R11", 1'b0, 'hF00AF, 15, 0, 2);
    sendReq("R11", 1'b1, 'hF00FF, 15, 0, 2);
  endtask

  task automatic testBadPosition();
    sendReq("R13", 1'b1, 'hF0010, 0, 0, 0);
    sendReq("R13", 1'b0, 'hF0010, 0, 0, 9);
    sendReq("R13", 1'b0, 'hF0240, 0, 0, 15);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    reqValid = 1'b1; reqIsWrite = 1'b0; reqAddr = 20'hF0000; reqLen = 4'd1;
    rptPosition = 4'd2;
    @(negedge clk);
    checkEq("R2", "b2b first valid", int'(decValid), 1);
    checkEq("R4", "b2b first action", int'(decAction), 1);
    reqIsWrite = 1'b1; reqAddr = 20'hF0150; reqLen = 4'd5;
    @(negedge clk);
    reqValid = 1'b0;
    checkEq("R2", "b2b second valid", int'(decValid), 1);
    checkEq("R7", "b2b second action", int'(decAction), 2);
    checkEq("R12", "b2b second len", int'(decLen), 5);
    @(negedge clk);
    checkEq("R2", "b2b idle", int'(decValid), 0);
  endtask

  task automatic testBackToTransparent();
    sendReq("R10", 1'b1, 'hF0003, 0, 'h00, 2);
    sendReq("R10", 1'b1, 'hF0003, 0, 'h55, 2);
    sendReq("R3", 1'b1, 'hF0100, 0, 0, 2);
    sendReq("R3", 1'b0, 'hF0000, 0, 0, 2);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    nVec++;
    nBad++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish();
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqIsWrite = 1'b0; reqAddr = '0;
    reqLen = '0; reqWrData = '0; rptPosition = 4'd1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTransparent();
    testModeWrites();
    testCap();
    testWindows();
    testOutside();
    testStartOnly();
    testBadPosition();
    testBackToBack();
    testBackToTransparent();
    repeat (2) @(negedge clk);
    finish();
  end

endmodule